// File: doc/BRIEF.md
# Multiplexed 16-bit Bus to 8-bit I/O Peripheral Bridge

This block sits between a CPU with a 16-bit multiplexed address/data bus and a single 8-bit I/O peripheral, such as an arithmetic coprocessor. While the address strobe is low it captures the address, the four status lines and the direction line. When the strobe rises it holds them for the rest of the bus cycle. From the held values it decides whether the cycle is an I/O access to the peripheral. If so, it drives the peripheral's chip select and register select, and it drives the read or write strobe for as long as the data strobe is active.

The CPU bus puts the more significant byte of a word at the even address. An 8-bit device wired to the low data byte therefore answers only odd addresses, and one wired to the high byte answers only even addresses. The parameter `LANE_LOW` picks the lane. That choice fixes both the required value of address bit 0 and the half of the bus that carries the peripheral's byte. A slow peripheral holds its ready input low. The bridge then requests wait states, which stretch the bus cycle without touching the clock.

All logic runs on one clock. The strobes `as_n` and `ds_n` are active low and are taken as synchronous to that clock.

Top module: `mux16_io8_bridge`

## Requirements
- R1: Chip select (`per_cs_n` low) is active only after `as_n` has risen, and only when all three of these hold for the captured values: the status equals 4'b0010, address bits 15..2 equal `base_addr`, and address bit 0 is 1 with `LANE_LOW`=1 (0 with `LANE_LOW`=0).
- R2: The address, status and direction are taken from the bus on every clock edge at which `as_n` is low. Once `as_n` is high, changes on `ad_i`, `st` or `rw` have no effect until the next strobe.
- R3: `per_rs` equals bit 1 of the captured address.
- R4: `per_rd_n` is low only while chip select is active, `ds_n` is low and the captured `rw` is 1 (read). `per_wr_n` is low only under the same conditions with captured `rw` 0 (write). The two strobes are never low together.
- R5: `wait_n` is low while chip select and `ds_n` are both active and `per_rdy` is low. It stays low in the clock where `per_rdy` first reads high and goes high one clock later. If `per_rdy` was already high on the previous edge, no wait is requested.
- R6: With `LANE_LOW`=1, `ad_o` carries `per_d_i` in bits 7..0 and zero in bits 15..8. `ad_oe` is high exactly while the read strobe is active.
- R7: With `LANE_LOW`=1, `per_d_o` equals `ad_i[7:0]`.
- R8: The bus cycle ends on the first clock edge at which `ds_n` reads high after reading low. Chip select is then inactive until the next address strobe.
- R9: During and right after reset, `per_cs_n`, `per_rd_n`, `per_wr_n` and `wait_n` are high and `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 16 | Multiplexed address/data from the CPU |
| ad_o | output | 16 | Read data toward the CPU, on the selected lane |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | Direction, 1 = read, 0 = write |
| st | input | 4 | Bus status code |
| base_addr | input | 14 | Address bits 15..2 that the peripheral answers |
| per_cs_n | output | 1 | Peripheral chip select, active low |
| per_rs | output | 1 | Register select (data vs status/command) |
| per_rd_n | output | 1 | Peripheral read strobe, active low |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| per_d_i | input | 8 | Byte read from the peripheral |
| per_d_o | output | 8 | Byte written to the peripheral |
| per_rdy | input | 1 | Peripheral ready, high when done |
| wait_n | output | 1 | Wait request to the CPU, active low |

## Verification
Two functions can land in the same clock. The wait release can coincide with the read or write strobe, and the moment the bus reuses its lines for data can coincide with the held address that drives the select outputs. The bench provokes both. It drops `ds_n` in the same clock that it replaces the address on `ad_i` with write data or unrelated bits. It also raises `per_rdy` after 0, 1 and 3 clocks of strobe. A behavioural model, stepped on each clock edge, judges `per_cs_n`, `per_rs`, the strobes and `wait_n` on every clock. Directed checks confirm that select and register select still follow the captured address, and that the wait ends exactly one clock after ready.

// File: rtl/mux16_io8_bridge.sv
module mux16_io8_bridge #(
  parameter int             DATA_W   = 8,
  parameter int             STAT_W   = 4,
  parameter logic [STAT_W-1:0] IO_CODE = 4'b0010,
  parameter bit             LANE_LOW = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*DATA_W-1:0]     ad_i,
  output logic [2*DATA_W-1:0]     ad_o,
  output logic                    ad_oe,
  input  logic                    as_n,
  input  logic                    ds_n,
  input  logic                    rw,
  input  logic [STAT_W-1:0]       st,
  input  logic [2*DATA_W-3:0]     base_addr,
  output logic                    per_cs_n,
  output logic                    per_rs,
  output logic                    per_rd_n,
  output logic                    per_wr_n,
  input  logic [DATA_W-1:0]       per_d_i,
  output logic [DATA_W-1:0]       per_d_o,
  input  logic                    per_rdy,
  output logic                    wait_n
);
  localparam int BUS_W = 2 * DATA_W;

  logic [BUS_W-1:0]  addr_q;
  logic [STAT_W-1:0] st_q;
  logic              rw_q, cyc_q, ds_q, rdy_q;
  logic              hit, sel, rd_act, wr_act, wait_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      st_q   <= '0;
      rw_q   <= 1'b1;
      cyc_q  <= 1'b0;
      ds_q   <= 1'b1;
    end else begin
      if (!as_n) begin
        addr_q <= ad_i;
        st_q   <= st;
        rw_q   <= rw;
        cyc_q  <= 1'b1;
      end else if (!ds_q && ds_n) begin
        cyc_q  <= 1'b0;
      end
      ds_q <= ds_n;
    end
  end

  always_ff @(posedge clk) rdy_q <= per_rdy;

  assign hit      = (st_q == IO_CODE) &&
                    (addr_q[BUS_W-1:2] == base_addr) &&
                    (addr_q[0] == LANE_LOW);
  assign sel      = cyc_q & as_n & hit;
  assign rd_act   = sel & ~ds_n & rw_q;
  assign wr_act   = sel & ~ds_n & ~rw_q;
  assign wait_act = sel & ~ds_n & ~(per_rdy & rdy_q);

  assign per_cs_n = ~sel;
  assign per_rs   = addr_q[1];
  assign per_rd_n = ~rd_act;
  assign per_wr_n = ~wr_act;
  assign wait_n   = ~wait_act;
  assign ad_oe    = rd_act;

  generate
    if (LANE_LOW) begin : g_low
      assign ad_o    = {{DATA_W{1'b0}}, per_d_i};
      assign per_d_o = ad_i[DATA_W-1:0];
    end else begin : g_high
      assign ad_o    = {per_d_i, {DATA_W{1'b0}}};
      assign per_d_o = ad_i[BUS_W-1:DATA_W];
    end
  endgenerate
endmodule

// File: rtl/mux16_io8_bridge_chk.sv
module mux16_io8_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic ds_n,
  input logic per_rdy,
  input logic per_cs_n,
  input logic per_rs,
  input logic per_rd_n,
  input logic per_wr_n,
  input logic wait_n,
  input logic ad_oe
);
  assert_cs_after_as_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !per_cs_n |-> as_n);
  assert_rs_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n && $past(as_n)) |-> $stable(per_rs));
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!per_rd_n && !per_wr_n));
  assert_rd_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !per_rd_n |-> (!per_cs_n && !ds_n));
  assert_wr_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !per_wr_n |-> (!per_cs_n && !ds_n));
  assert_wait_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_cs_n && !ds_n && !per_rdy) |-> !wait_n);
  assert_wait_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rdy && $past(per_rdy)) |-> wait_n);
  assert_wait_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |-> (!per_cs_n && !ds_n));
  assert_oe_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !per_rd_n);
endmodule

bind mux16_io8_bridge mux16_io8_bridge_chk i_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .per_rdy(per_rdy),
  .per_cs_n(per_cs_n), .per_rs(per_rs), .per_rd_n(per_rd_n),
  .per_wr_n(per_wr_n), .wait_n(wait_n), .ad_oe(ad_oe)
);

// File: tb/test_mux16_io8_bridge.sv
module test_mux16_io8_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o;
  logic        ad_oe;
  logic        as_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [3:0]  st = '0;
  logic [13:0] base_addr = 14'h0A31;
  logic        per_cs_n, per_rs, per_rd_n, per_wr_n, wait_n, per_rdy = 1'b0;
  logic [7:0]  per_d_i = 8'h5A;
  logic [7:0]  per_d_o;

  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  mux16_io8_bridge i_mux16_io8_bridge (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .as_n(as_n), .ds_n(ds_n), .rw(rw), .st(st), .base_addr(base_addr),
    .per_cs_n(per_cs_n), .per_rs(per_rs), .per_rd_n(per_rd_n),
    .per_wr_n(per_wr_n), .per_d_i(per_d_i), .per_d_o(per_d_o),
    .per_rdy(per_rdy), .wait_n(wait_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped on each clock edge
  logic [15:0] m_addr = '0;
  logic [3:0]  m_st = '0;
  logic        m_rw = 1'b1, m_cyc = 1'b0, m_ds = 1'b1, m_rdy = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = '0; m_st = '0; m_rw = 1'b1; m_cyc = 1'b0; m_ds = 1'b1;
    end else begin
      if (!as_n) begin
        m_addr = ad_i; m_st = st; m_rw = rw; m_cyc = 1'b1;
      end else if (!m_ds && ds_n) m_cyc = 1'b0;
      m_ds = ds_n;
    end
    m_rdy = per_rdy;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic e_sel, e_rd, e_wr, e_wait;
      e_sel  = m_cyc && as_n && m_st == 4'b0010 &&
               m_addr[15:2] == base_addr && m_addr[0];
      e_rd   = e_sel && !ds_n && m_rw;
      e_wr   = e_sel && !ds_n && !m_rw;
      e_wait = e_sel && !ds_n && !(per_rdy && m_rdy);
      chk("R1 cs_n", {15'd0, per_cs_n}, {15'd0, !e_sel});
      chk("R3 rs", {15'd0, per_rs}, {15'd0, m_addr[1]});
      chk("R4 rd_n", {15'd0, per_rd_n}, {15'd0, !e_rd});
      chk("R4 wr_n", {15'd0, per_wr_n}, {15'd0, !e_wr});
      chk("R5 wait_n", {15'd0, wait_n}, {15'd0, !e_wait});
      chk("R6 ad_oe", {15'd0, ad_oe}, {15'd0, e_rd});
      chk("R6 ad_o", ad_o, {8'h00, per_d_i});
      chk("R7 per_d_o", {8'h00, per_d_o}, {8'h00, ad_i[7:0]});
    end
  end

  task automatic io_cyc(input logic [15:0] a, input logic [3:0] s, input logic r,
                        input logic [15:0] wd, input int dly, input logic exp_sel);
    @(negedge clk);
    as_n = 1'b0; ad_i = a; st = s; rw = r; per_rdy = (dly == 0);
    @(negedge clk);
    as_n = 1'b1;
    @(negedge clk);
    ad_i = r ? ~a : wd; st = 4'b1000; rw = ~r; ds_n = 1'b0;
    #1;
    chk("R2 cs held", {15'd0, per_cs_n}, {15'd0, !exp_sel});
    chk("R2 rs held", {15'd0, per_rs}, {15'd0, a[1]});
    if (exp_sel && dly > 0) chk("R5 wait asserted", {15'd0, wait_n}, 16'd0);
    for (int k = 1; k < dly; k++) @(negedge clk);
    if (dly > 0) begin
      @(negedge clk);
      per_rdy = 1'b1;
      #1;
      if (exp_sel) chk("R5 wait held on ready clock", {15'd0, wait_n}, 16'd0);
    end
    @(negedge clk);
    #1;
    chk("R5 wait released", {15'd0, wait_n}, 16'd1);
    if (exp_sel && !r) chk("R7 write byte", {8'h00, per_d_o}, {8'h00, wd[7:0]});
    if (exp_sel && r) chk("R6 read lane", ad_o, {8'h00, per_d_i});
    @(negedge clk);
    ds_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R8 cs off after cycle", {15'd0, per_cs_n}, 16'd1);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset cs_n", {15'd0, per_cs_n}, 16'd1);
    chk("R9 reset rd_n", {15'd0, per_rd_n}, 16'd1);
    chk("R9 reset wr_n", {15'd0, per_wr_n}, 16'd1);
    chk("R9 reset wait_n", {15'd0, wait_n}, 16'd1);
    chk("R9 reset ad_oe", {15'd0, ad_oe}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R3 R4: reads of data and status registers, odd address
    io_cyc({14'h0A31, 2'b01}, 4'b0010, 1'b1, 16'h0000, 0, 1'b1);
    per_d_i = 8'hC3;
    io_cyc({14'h0A31, 2'b11}, 4'b0010, 1'b1, 16'h0000, 1, 1'b1);
    // R4 R7: write with wait states
    io_cyc({14'h0A31, 2'b11}, 4'b0010, 1'b0, 16'hBE96, 3, 1'b1);
    io_cyc({14'h0A31, 2'b01}, 4'b0010, 1'b0, 16'h1234, 0, 1'b1);
    // R1: rejected cycles
    io_cyc({14'h0A31, 2'b00}, 4'b0010, 1'b1, 16'h0000, 1, 1'b0);
    io_cyc({14'h0A31, 2'b01}, 4'b1000, 1'b0, 16'h00FF, 1, 1'b0);
    io_cyc({14'h0A30, 2'b01}, 4'b0010, 1'b1, 16'h0000, 0, 1'b0);
    // R1 with a new base
    base_addr = 14'h3FFF;
    io_cyc(16'hFFFD, 4'b0010, 1'b0, 16'h00A5, 2, 1'b1);
    io_cyc(16'hFFFF, 4'b0010, 1'b1, 16'h0000, 1, 1'b1);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule